// File: doc/BRIEF.md
# UART Receive/Transmit Status and Interrupt Controller

This block keeps the status and interrupt state of one UART channel. It holds a 16-entry receive queue in which every entry carries a received character and its three error flags (parity, framing, break). It also holds a 16-entry transmit queue, and it takes a shift-register-empty input from the transmitter. From these it builds a line status byte and an interrupt enable byte, and it drives one host interrupt line with an identification code. A byte-wide register bus gives the host access. The receive shifter pushes characters in through a separate port, and the transmitter pulls bytes out through a take strobe.

The receive interrupt is level based. In queue mode it is asserted while the occupancy is at or above a selectable trigger level, and it drops once the occupancy falls below that level. In single-character mode it is asserted while a character is held. When all enable bits are clear, the host polls the status byte and no interrupt is raised. A small state machine keeps the source being reported. On each clock it moves to the highest-priority pending source. The states are `SRC_NONE`, `SRC_TXR` (transmit ready), `SRC_RXD` (receive data) and `SRC_LINE` (line status). The state register is updated every cycle from the current requests. The transitions are: any state to `SRC_LINE` when a line request is pending; otherwise to `SRC_RXD` when a receive request is pending; otherwise to `SRC_TXR` when a transmit request is pending; otherwise to `SRC_NONE`.

Register map (3-bit address): 0 reads pop the receive head and writes push the transmit queue. 1 is the enable byte. 2 reads the identification code and writes the control byte. 5 reads the line status byte.

Top module: `uart_stat_core`

## Requirements
- R1: After reset the enable byte reads 0x00, the identification code reads 0x01, `irq` is low, and the line status reads 0x60 while `tsr_empty` is high.
- R2: Bits 3..0 of the enable byte are stored as written: bit0 enables receive data, bit1 transmit ready, bit2 line status, and bit3 is stored without effect. Bits 7..4 always read 0.
- R3: The receive queue returns characters in arrival order, up to 16 entries. A read at address 0 returns the head and removes it.
- R4: In queue mode (control bit0 = 1), control bits 7:6 select a trigger of 1, 4, 8 or 14 entries. With enable bit0 set, `irq` is high one cycle after the occupancy reaches the trigger, and low one cycle after it falls below the trigger.
- R5: A push while the queue is at capacity discards the character and sets line status bit1. With enable bit2 set, `irq` rises on the next cycle.
- R6: Line status bit0 is 1 exactly while the receive queue is non-empty.
- R7: Line status bits 2, 3 and 4 show the parity, framing and break flags of the head character. Bit7 is 1 while any queued character has an error. Reading the line status clears bit1 and hides bits 2..4 until the head changes. Bit7 is not affected by that read.
- R8: Line status bit5 is 1 when the transmit queue is empty. Bit6 is 1 when the transmit queue is empty and `tsr_empty` is high.
- R9: While enable bits 2..0 are all 0, `irq` stays low whatever the queue and error state.
- R10: Setting enable bit1 while the transmit queue is empty raises `irq` on the next cycle. Reading the identification code while it reports transmit ready acknowledges the interrupt. A later transmit write re-arms it, so it fires again when the queue drains.
- R11: The priority from highest to lowest is line status (code 0x06), receive data (0x04) and transmit ready (0x02). The code reads 0x01 when nothing is pending, and `irq` is high exactly when the code is not 0x01.
- R12: With control bit0 = 0 each queue holds one character, and the receive interrupt is asserted while that character is held. Any change of control bit0 clears both queues. Control bit1 clears the receive queue and bit2 clears the transmit queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at clock edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| rx_push | input | 1 | Receive shifter delivers a character |
| rx_char | input | 8 | Received character |
| rx_perr | input | 1 | Parity error flag of the character |
| rx_ferr | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Break flag of the character |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_data | output | 8 | Byte at the transmit queue head |
| tx_take | input | 1 | Transmitter takes the head byte |
| tsr_empty | input | 1 | Transmit shift register is empty |
| irq | output | 1 | Host interrupt |

## Verification
A wrong occupancy count or a stuck error counter shows up at the ports within one clock: the line status byte goes wrong, and `irq` goes wrong one cycle later, because the source state machine registers every request. The bench reads the status byte after every push and pop. It sweeps all four trigger levels up to full and back down again, so a miscounted entry or an off-by-one trigger compare is seen at the next sample. A wrong acknowledge or mask bit stays latched, so it appears as an interrupt that will not clear or one that never fires. The bench checks both kinds after each acknowledging read.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_TXR  = 2'd1,
        SRC_RXD  = 2'd2,
        SRC_LINE = 2'd3
    } src_e;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_IEN  = 3'd1;
    localparam logic [2:0] A_ID   = 3'd2;
    localparam logic [2:0] A_LST  = 3'd5;

    function automatic int trig_entries(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [7:0] src_code(input src_e s);
        case (s)
            SRC_LINE: return 8'h06;
            SRC_RXD:  return 8'h04;
            SRC_TXR:  return 8'h02;
            default:  return 8'h01;
        endcase
    endfunction

endpackage

// File: rtl/uart_stat_fifo.sv
module uart_stat_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    always_comb begin
        do_push = push && !clr && (count < CW'(DEPTH));
        do_pop  = pop && !clr && (count != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= wdata;
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/uart_stat_irq_fsm.sv
module uart_stat_irq_fsm
    import uart_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_req,
    input  logic       rxd_req,
    input  logic       txr_req,
    output src_e       src,
    output logic       irq,
    output logic [7:0] id_code
);

    src_e state_q;
    src_e state_d;

    // Each cycle: move to the highest pending source.
    always_comb begin
        unique case (state_q)
            SRC_NONE, SRC_TXR, SRC_RXD, SRC_LINE: begin
                if (line_req)      state_d = SRC_LINE;
                else if (rxd_req)  state_d = SRC_RXD;
                else if (txr_req)  state_d = SRC_TXR;
                else               state_d = SRC_NONE;
            end
            default: state_d = SRC_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        src     = state_q;
        id_code = src_code(state_q);
        unique case (state_q)
            SRC_NONE: irq = 1'b0;
            default:  irq = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_stat_core.sv
module uart_stat_core
    import uart_stat_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_push,
    input  logic [7:0] rx_char,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       rx_brk,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_take,
    input  logic       tsr_empty,
    output logic       irq
);

    localparam int CW   = $clog2(DEPTH + 1);
    localparam int RXW  = 8 + 3;

    // control state
    logic [3:0]    ier_q;
    logic          fifo_en_q;
    logic [1:0]    trig_sel_q;
    logic          ovr_q;
    logic          head_mask_q;
    logic          tx_ack_q;
    logic [CW-1:0] err_cnt_q;

    // queue signals
    logic [CW-1:0]  rx_cnt, tx_cnt, rx_cap;
    logic [RXW-1:0] rx_head;
    logic [7:0]     tx_head;
    logic           rx_clr, tx_clr;
    logic           rx_accept, rx_ovf, rx_pop;
    logic           tx_push, tx_pop;
    logic           rx_empty, tx_empty;
    logic [2:0]     push_err, head_err;

    // bus decode
    logic wr_ien, wr_ctl, rd_lst, rd_id, rd_data, wr_data, mode_flip;

    // status and requests
    logic [7:0] lsr;
    logic       line_req, rxd_req, txr_req;
    logic [7:0] id_code;
    src_e       src;

    always_comb begin
        wr_ien    = bus_wr && (bus_addr == A_IEN);
        wr_ctl    = bus_wr && (bus_addr == A_ID);
        wr_data   = bus_wr && (bus_addr == A_DATA);
        rd_lst    = bus_rd && (bus_addr == A_LST);
        rd_id     = bus_rd && (bus_addr == A_ID);
        rd_data   = bus_rd && (bus_addr == A_DATA);
        mode_flip = wr_ctl && (bus_wdata[0] != fifo_en_q);
        rx_clr    = wr_ctl && (bus_wdata[1] || mode_flip);
        tx_clr    = wr_ctl && (bus_wdata[2] || mode_flip);
    end

    always_comb begin
        rx_cap    = fifo_en_q ? CW'(DEPTH) : CW'(1);
        rx_empty  = (rx_cnt == '0);
        tx_empty  = (tx_cnt == '0);
        rx_accept = rx_push && (rx_cnt < rx_cap);
        rx_ovf    = rx_push && !rx_accept;
        rx_pop    = rd_data && !rx_empty;
        tx_push   = wr_data && (tx_cnt < rx_cap);
        tx_pop    = tx_take && !tx_empty;
        push_err  = {rx_brk, rx_ferr, rx_perr};
        head_err  = rx_head[RXW-1:8];
    end

    uart_stat_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (rx_accept),
        .pop   (rx_pop),
        .wdata ({push_err, rx_char}),
        .head  (rx_head),
        .count (rx_cnt)
    );

    uart_stat_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (tx_push),
        .pop   (tx_pop),
        .wdata (bus_wdata),
        .head  (tx_head),
        .count (tx_cnt)
    );

    // register file and sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier_q       <= '0;
            fifo_en_q   <= 1'b0;
            trig_sel_q  <= '0;
            ovr_q       <= 1'b0;
            head_mask_q <= 1'b0;
            tx_ack_q    <= 1'b0;
            err_cnt_q   <= '0;
        end else begin
            if (wr_ien) ier_q <= bus_wdata[3:0];
            if (wr_ctl) begin
                fifo_en_q  <= bus_wdata[0];
                trig_sel_q <= bus_wdata[7:6];
            end

            if (rx_ovf)      ovr_q <= 1'b1;
            else if (rd_lst) ovr_q <= 1'b0;

            if (rx_clr || rx_pop || (rx_accept && rx_empty))
                head_mask_q <= 1'b0;
            else if (rd_lst)
                head_mask_q <= 1'b1;

            if (tx_push || (wr_ien && bus_wdata[1] && !ier_q[1]))
                tx_ack_q <= 1'b0;
            else if (rd_id && (src == SRC_TXR))
                tx_ack_q <= 1'b1;

            if (rx_clr)
                err_cnt_q <= '0;
            else
                err_cnt_q <= err_cnt_q
                           + CW'(rx_accept && (push_err != '0))
                           - CW'(rx_pop && (head_err != '0));
        end
    end

    always_comb begin
        lsr[0]   = !rx_empty;
        lsr[1]   = ovr_q;
        lsr[4:2] = (rx_empty || head_mask_q) ? 3'b000 : head_err;
        lsr[5]   = tx_empty;
        lsr[6]   = tx_empty && tsr_empty;
        lsr[7]   = (err_cnt_q != '0);
    end

    always_comb begin
        line_req = ier_q[2] && (lsr[1] || (lsr[4:2] != '0));
        rxd_req  = ier_q[0] && (fifo_en_q ? (rx_cnt >= CW'(trig_entries(trig_sel_q)))
                                          : !rx_empty);
        txr_req  = ier_q[1] && tx_empty && !tx_ack_q;
    end

    uart_stat_irq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_req (line_req),
        .rxd_req  (rxd_req),
        .txr_req  (txr_req),
        .src      (src),
        .irq      (irq),
        .id_code  (id_code)
    );

    always_comb begin
        unique case (bus_addr)
            A_DATA:  bus_rdata = rx_head[7:0];
            A_IEN:   bus_rdata = {4'b0000, ier_q};
            A_ID:    bus_rdata = id_code;
            A_LST:   bus_rdata = lsr;
            default: bus_rdata = 8'h00;
        endcase
    end

    assign tx_valid = !tx_empty;
    assign tx_data  = tx_head;

endmodule

// File: rtl/uart_stat_core_chk.sv
module uart_stat_core_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic [3:0]    ier_q,
    input logic          rx_push,
    input logic          rx_clr,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] rx_cap,
    input logic [7:0]    lsr,
    input logic [7:0]    id_code
);

    a_r9_polled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[2:0] == 3'b000) |=> !irq);

    a_r5_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && (rx_cnt == rx_cap)) |=> lsr[1]);

    a_r3_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH));

    a_r7_anyerr_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[7] |-> lsr[0]);

    a_r6_ready_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && (rx_cnt == '0) && !rx_clr) |=> lsr[0]);

    a_r11_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (id_code == 8'h01));

endmodule

bind uart_stat_core uart_stat_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .ier_q   (ier_q),
    .rx_push (rx_push),
    .rx_clr  (rx_clr),
    .rx_cnt  (rx_cnt),
    .rx_cap  (rx_cap),
    .lsr     (lsr),
    .id_code (id_code)
);

// File: tb/uart_stat_core_bench.sv
`timescale 1ns/1ps
module uart_stat_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_push = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_take = 1'b0;
    logic       tsr_empty = 1'b1;
    logic       irq;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    uart_stat_core u_uart_stat_core (.*);

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        cyc();
        bus_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] c, input logic p, input logic f, input logic b);
        rx_char = c; rx_perr = p; rx_ferr = f; rx_brk = b; rx_push = 1'b1;
        cyc();
        rx_push = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        expect_reg("R1 ier", 3'd1, 8'h00);
        expect_reg("R1 id", 3'd2, 8'h01);
        expect_reg("R1 lsr", 3'd5, 8'h60);

        // R2 enable byte width
        wr(3'd1, 8'hF8);
        expect_reg("R2 ier upper", 3'd1, 8'h08);
        wr(3'd1, 8'h00);

        // R4 / R3 / R6 trigger sweep
        for (int s = 0; s < 4; s++) begin
            int trig;
            trig = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            wr(3'd2, 8'((s << 6) | 3));
            wr(3'd1, 8'h01);
            for (int k = 1; k <= 16; k++) begin
                push(8'((s << 4) + k), 1'b0, 1'b0, 1'b0);
                cyc();
                check("R4 rise", {7'b0, irq}, (k >= trig) ? 8'h01 : 8'h00);
            end
            expect_reg("R6 full lsr", 3'd5, 8'h61);
            for (int k = 1; k <= 16; k++) begin
                rd(3'd0, v);
                check("R3 order", v, 8'((s << 4) + k));
                cyc();
                check("R4 fall", {7'b0, irq}, ((16 - k) >= trig) ? 8'h01 : 8'h00);
            end
            expect_reg("R6 empty lsr", 3'd5, 8'h60);
        end

        // R5 overrun
        wr(3'd2, 8'h03);
        wr(3'd1, 8'h04);
        for (int k = 0; k < 16; k++) push(8'h30 + 8'(k), 1'b0, 1'b0, 1'b0);
        cyc();
        check("R5 no irq before", {7'b0, irq}, 8'h00);
        push(8'hEE, 1'b0, 1'b0, 1'b0);
        cyc();
        check("R5 irq", {7'b0, irq}, 8'h01);
        expect_reg("R11 line code", 3'd2, 8'h06);
        expect_reg("R5 lsr ovr", 3'd5, 8'h63);
        expect_reg("R7 ovr cleared", 3'd5, 8'h61);
        check("R5 irq cleared", {7'b0, irq}, 8'h00);
        for (int k = 0; k < 16; k++) begin
            rd(3'd0, v);
            check("R5 kept data", v, 8'h30 + 8'(k));
        end
        expect_reg("R5 drained", 3'd5, 8'h60);

        // R7 per-character errors
        push(8'h41, 1'b1, 1'b0, 1'b0);
        cyc();
        check("R7 head err irq", {7'b0, irq}, 8'h01);
        expect_reg("R7 parity", 3'd5, 8'hE5);
        expect_reg("R7 masked", 3'd5, 8'hE1);
        check("R7 irq after read", {7'b0, irq}, 8'h00);
        push(8'h42, 1'b0, 1'b1, 1'b0);
        expect_reg("R7 any err", 3'd5, 8'hE1);
        rd(3'd0, v);
        check("R7 pop data", v, 8'h41);
        expect_reg("R7 framing", 3'd5, 8'hE9);
        check("R7 new head irq", {7'b0, irq}, 8'h01);
        rd(3'd0, v);
        expect_reg("R7 cleared", 3'd5, 8'h60);
        push(8'h00, 1'b0, 1'b0, 1'b1);
        expect_reg("R7 break", 3'd5, 8'hF1);
        rd(3'd0, v);
        push(8'h50, 1'b0, 1'b0, 1'b0);
        push(8'h51, 1'b1, 1'b0, 1'b0);
        expect_reg("R7 err behind head", 3'd5, 8'hE1);
        wr(3'd2, 8'h03);

        // R10 transmit ready, R8 transmit status
        wr(3'd1, 8'h02);
        cyc();
        check("R10 immediate", {7'b0, irq}, 8'h01);
        expect_reg("R10 code", 3'd2, 8'h02);
        cyc();
        check("R10 acked", {7'b0, irq}, 8'h00);
        wr(3'd0, 8'h5A);
        check("R8 tx valid", {7'b0, tx_valid}, 8'h01);
        check("R8 tx data", tx_data, 8'h5A);
        expect_reg("R8 tx busy", 3'd5, 8'h00);
        check("R10 no irq busy", {7'b0, irq}, 8'h00);
        tx_take = 1'b1; cyc(); tx_take = 1'b0;
        cyc();
        check("R10 rearmed", {7'b0, irq}, 8'h01);
        expect_reg("R8 both empty", 3'd5, 8'h60);
        tsr_empty = 1'b0;
        expect_reg("R8 tsr busy", 3'd5, 8'h20);
        tsr_empty = 1'b1;

        // R12 single-character mode
        wr(3'd1, 8'h05);
        wr(3'd2, 8'h00);
        push(8'h11, 1'b0, 1'b0, 1'b0);
        cyc();
        check("R12 held irq", {7'b0, irq}, 8'h01);
        expect_reg("R12 rx code", 3'd2, 8'h04);
        push(8'h22, 1'b0, 1'b0, 1'b0);
        cyc();
        expect_reg("R12 overrun code", 3'd2, 8'h06);
        expect_reg("R12 lsr", 3'd5, 8'h63);
        cyc();
        expect_reg("R11 rx after line", 3'd2, 8'h04);
        rd(3'd0, v);
        check("R12 first kept", v, 8'h11);
        expect_reg("R12 empty", 3'd5, 8'h60);
        check("R12 irq low", {7'b0, irq}, 8'h00);
        push(8'h33, 1'b0, 1'b0, 1'b0);
        wr(3'd2, 8'h01);
        expect_reg("R12 flip clears", 3'd5, 8'h60);

        // R9 polled mode
        wr(3'd1, 8'h00);
        for (int k = 0; k < 17; k++) begin
            push(8'(k), (k == 0), 1'b0, 1'b0);
            cyc();
            check("R9 quiet", {7'b0, irq}, 8'h00);
        end
        expect_reg("R9 status live", 3'd5, 8'hE7);
        wr(3'd2, 8'h03);

        // R11 priority walk
        wr(3'd1, 8'h07);
        push(8'h77, 1'b1, 1'b0, 1'b0);
        cyc();
        expect_reg("R11 line first", 3'd2, 8'h06);
        expect_reg("R11 lsr", 3'd5, 8'hE5);
        cyc();
        expect_reg("R11 rx second", 3'd2, 8'h04);
        rd(3'd0, v);
        cyc();
        expect_reg("R11 tx third", 3'd2, 8'h02);
        cyc();
        expect_reg("R11 none", 3'd2, 8'h01);
        check("R11 irq low", {7'b0, irq}, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule